// File: doc/BRIEF.md
# Control Register Completer with Lane Decode

This block sits behind a host memory-request stream and turns each request into an access to a small bank of 128-bit control registers. A request carries a byte address, a count of 32-bit words, a tag and up to four words of write data. Writes land in the addressed register; reads are answered one cycle later with a completion that repeats the tag and word count and carries the data, packed from the lowest word upward.

The two lowest address bits are dropped, so every access is whole 32-bit words and no byte masking exists. Address bits 3:2 pick the starting 32-bit lane inside a 128-bit register, and a multi-word access walks upward through the lanes, wrapping within the same register. One bank therefore serves 32-, 64- and 128-bit host accesses. The bank holds a transfer descriptor (start and end address in one register, transfer size in the next), a transfer-enable register that the transfer engine clears through a strobe when it finishes, and a read-only window that mirrors base-address values supplied from outside. Every other offset reads as zero and ignores writes.

Top module: `regbank_completer`

## Requirements
- R1: After reset the descriptor address, size and enable registers are all zero and no completion is presented.
- R2: Request address bits 1:0 are ignored; an access at byte address A behaves exactly as one at A with those two bits cleared.
- R3: Address bits 3:2 select the starting 32-bit lane (lane n occupies register bits 32n+31:32n); a one-word write changes only that lane of the register.
- R4: A request of N words (N from 1 to 4) touches lanes (L+k) mod 4 for k = 0..N-1, where L is the starting lane; write word k is request data bits 32k+31:32k.
- R5: Register index is address bits 11:4. Index 0 (offsets 0x0-0xF) is the descriptor address register: lanes 0-1 form the start address and lanes 2-3 (offset 0x8) the end address; index 1 (offset 0x10) is the size register; index 64 (offset 0x400) is the enable register. All three are driven onto output ports.
- R6: Indexes 48, 49 and 50 (offsets 0x300, 0x310, 0x320) read back the matching 128-bit slice of the mirror input (slice j at bits 128j+127:128j); host writes there change nothing.
- R7: A read accepted on a clock edge produces a completion valid for exactly the following cycle, with the request tag, the request word count, word k of the read in data bits 32k+31:32k and all data bits above word N-1 zero.
- R8: Reads of any other index return all-zero data, and writes to them change no register.
- R9: The clear strobe resets bit 0 of the enable register on the next edge; a host write to the enable register on the same edge takes precedence over the strobe.
- R10: A write request produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte address of the access |
| req_dwords | input | 3 | Number of 32-bit words, 1 to 4 |
| req_tag | input | 8 | Request tag returned on the completion |
| req_wdata | input | 128 | Write data, word k in bits 32k+31:32k |
| mirror_in | input | 384 | Values shown in the read-only window, one 128-bit slice per register |
| enable_clr | input | 1 | Clears enable bit 0 |
| cpl_valid | output | 1 | Completion present |
| cpl_tag | output | 8 | Tag of the answered read |
| cpl_dwords | output | 3 | Word count of the answered read |
| cpl_data | output | 128 | Read data, word k in bits 32k+31:32k |
| desc_addr | output | 128 | Descriptor address register (start in low half, end in high half) |
| desc_size | output | 128 | Descriptor size register |
| desc_enable | output | 128 | Enable register |

## Verification
A wrong lane pointer or bad write merge shows on the descriptor output ports on the very next cycle after the write, and on the completion data one cycle after any read of that register. A decode fault that lets a write reach an unmapped or read-only index corrupts a descriptor port immediately, while a read mux fault shows only in the completion of the next read to that index. Tag or count faults are visible in the same completion cycle, so every read checks them at once.

// File: rtl/regc_pkg.sv
package regc_pkg;
  localparam int DW_W     = 32;
  localparam int REG_W    = 128;
  localparam int LANES    = REG_W / DW_W;
  localparam int IDX_ADDR = 0;
  localparam int IDX_SIZE = 1;
  localparam int IDX_MIRR = 48;
  localparam int IDX_EN   = 64;

  // Lanes touched by an access of n words starting at lane l0, wrapping.
  function automatic logic [3:0] lane_mask(input logic [1:0] l0, input logic [2:0] n);
    logic [3:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) begin
      if (3'(k) < n) m[2'(l0 + 2'(k))] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [127:0] expand_mask(input logic [3:0] m);
    logic [127:0] e;
    for (int k = 0; k < LANES; k++) e[k*DW_W +: DW_W] = {DW_W{m[k]}};
    return e;
  endfunction

  // Rotate by s words toward higher lanes.
  function automatic logic [127:0] rot_up(input logic [127:0] v, input logic [1:0] s);
    return (v << {s, 5'd0}) | (v >> (8'd128 - {1'b0, s, 5'd0}));
  endfunction

  // Rotate by s words toward lower lanes.
  function automatic logic [127:0] rot_down(input logic [127:0] v, input logic [1:0] s);
    return (v >> {s, 5'd0}) | (v << (8'd128 - {1'b0, s, 5'd0}));
  endfunction

  // Keep words 0..n-1 only.
  function automatic logic [127:0] keep_low(input logic [127:0] v, input logic [2:0] n);
    return v & expand_mask(lane_mask(2'd0, n));
  endfunction
endpackage

// File: rtl/regc_decode.sv
module regc_decode #(
  parameter int ADDR_W   = 12,
  parameter int NUM_MIRR = 3,
  localparam int IDX_W   = ADDR_W - 4,
  localparam int SEL_W   = (NUM_MIRR > 1) ? $clog2(NUM_MIRR) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        lane0,
  output logic              hit_addr,
  output logic              hit_size,
  output logic              hit_en,
  output logic              hit_mirr,
  output logic [SEL_W-1:0]  mirr_sel
);
  import regc_pkg::*;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] rel;

  // Bits 1:0 are dropped: dword alignment.
  assign lane0    = addr[3:2];
  assign idx      = addr[ADDR_W-1:4];
  assign rel      = idx - IDX_W'(IDX_MIRR);
  assign hit_addr = (idx == IDX_W'(IDX_ADDR));
  assign hit_size = (idx == IDX_W'(IDX_SIZE));
  assign hit_en   = (idx == IDX_W'(IDX_EN));
  assign hit_mirr = (idx >= IDX_W'(IDX_MIRR)) && (rel < IDX_W'(NUM_MIRR));
  assign mirr_sel = rel[SEL_W-1:0];

  always_comb begin
    AST_ONE_HIT: assert ($onehot0({hit_addr, hit_size, hit_en, hit_mirr})); // R5
  end
endmodule

// File: rtl/regc_store.sv
module regc_store (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic         hit_addr,
  input  logic         hit_size,
  input  logic         hit_en,
  input  logic [1:0]   lane0,
  input  logic [2:0]   dwords,
  input  logic [127:0] wdata,
  input  logic         en_clr,
  output logic [127:0] r_addr,
  output logic [127:0] r_size,
  output logic [127:0] r_en
);
  import regc_pkg::*;
  logic [127:0] wmask;
  logic [127:0] wplaced;
  logic         wr_addr, wr_size, wr_en, wr_none;

  assign wmask   = expand_mask(lane_mask(lane0, dwords));
  assign wplaced = rot_up(wdata, lane0);
  assign wr_addr = wr_stb && hit_addr;
  assign wr_size = wr_stb && hit_size;
  assign wr_en   = wr_stb && hit_en;
  assign wr_none = wr_stb && !hit_addr && !hit_size && !hit_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_addr <= '0;
      r_size <= '0;
      r_en   <= '0;
    end else begin
      if (wr_addr) r_addr <= (r_addr & ~wmask) | (wplaced & wmask);
      if (wr_size) r_size <= (r_size & ~wmask) | (wplaced & wmask);
      if (wr_en)   r_en   <= (r_en & ~wmask) | (wplaced & wmask);
      else if (en_clr) r_en[0] <= 1'b0;
    end
  end

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_none && !en_clr) |=> ($stable(r_addr) && $stable(r_size) && $stable(r_en))); // R8
  AST_CLEAR_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !wr_en) |=> !r_en[0]); // R9
  AST_WRITE_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr |=> ((r_addr & ~$past(wmask)) == ($past(r_addr) & ~$past(wmask)))); // R3
endmodule

// File: rtl/regc_readback.sv
module regc_readback #(
  parameter int NUM_MIRR = 3,
  localparam int SEL_W   = (NUM_MIRR > 1) ? $clog2(NUM_MIRR) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_stb,
  input  logic [7:0]              tag,
  input  logic [2:0]              dwords,
  input  logic [1:0]              lane0,
  input  logic                    hit_addr,
  input  logic                    hit_size,
  input  logic                    hit_en,
  input  logic                    hit_mirr,
  input  logic [SEL_W-1:0]        mirr_sel,
  input  logic [127:0]            r_addr,
  input  logic [127:0]            r_size,
  input  logic [127:0]            r_en,
  input  logic [NUM_MIRR*128-1:0] mirror,
  output logic                    cpl_valid,
  output logic [7:0]              cpl_tag,
  output logic [2:0]              cpl_dwords,
  output logic [127:0]            cpl_data
);
  import regc_pkg::*;
  logic [127:0] picked;
  logic [127:0] mirr_word;

  always_comb begin
    mirr_word = '0;
    for (int j = 0; j < NUM_MIRR; j++) begin
      if (mirr_sel == SEL_W'(j)) mirr_word = mirror[j*128 +: 128];
    end
    if (hit_addr)      picked = r_addr;
    else if (hit_size) picked = r_size;
    else if (hit_en)   picked = r_en;
    else if (hit_mirr) picked = mirr_word;
    else               picked = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpl_valid  <= 1'b0;
      cpl_tag    <= '0;
      cpl_dwords <= '0;
      cpl_data   <= '0;
    end else begin
      cpl_valid <= rd_stb;
      if (rd_stb) begin
        cpl_tag    <= tag;
        cpl_dwords <= dwords;
        cpl_data   <= keep_low(rot_down(picked, lane0), dwords);
      end
    end
  end

  AST_SINGLE_WORD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_dwords == 3'd1) |-> (cpl_data[127:32] == '0)); // R7
endmodule

// File: rtl/regbank_completer.sv
module regbank_completer #(
  parameter int ADDR_W   = 12,
  parameter int TAG_W    = 8,
  parameter int NUM_MIRR = 3,
  localparam int SEL_W   = (NUM_MIRR > 1) ? $clog2(NUM_MIRR) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [2:0]              req_dwords,
  input  logic [TAG_W-1:0]        req_tag,
  input  logic [127:0]            req_wdata,
  input  logic [NUM_MIRR*128-1:0] mirror_in,
  input  logic                    enable_clr,
  output logic                    cpl_valid,
  output logic [TAG_W-1:0]        cpl_tag,
  output logic [2:0]              cpl_dwords,
  output logic [127:0]            cpl_data,
  output logic [127:0]            desc_addr,
  output logic [127:0]            desc_size,
  output logic [127:0]            desc_enable
);
  logic [1:0]       lane0;
  logic             hit_addr, hit_size, hit_en, hit_mirr;
  logic [SEL_W-1:0] mirr_sel;
  logic             wr_stb, rd_stb;
  logic [7:0]       tag8;
  logic [7:0]       cpl_tag8;

  assign wr_stb = req_valid && req_write;
  assign rd_stb = req_valid && !req_write;
  assign tag8   = 8'(req_tag);
  assign cpl_tag = TAG_W'(cpl_tag8);

  regc_decode #(.ADDR_W(ADDR_W), .NUM_MIRR(NUM_MIRR)) u_dec (
    .addr(req_addr), .lane0(lane0), .hit_addr(hit_addr), .hit_size(hit_size),
    .hit_en(hit_en), .hit_mirr(hit_mirr), .mirr_sel(mirr_sel)
  );

  regc_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .hit_addr(hit_addr),
    .hit_size(hit_size), .hit_en(hit_en), .lane0(lane0), .dwords(req_dwords),
    .wdata(req_wdata), .en_clr(enable_clr),
    .r_addr(desc_addr), .r_size(desc_size), .r_en(desc_enable)
  );

  regc_readback #(.NUM_MIRR(NUM_MIRR)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .tag(tag8), .dwords(req_dwords),
    .lane0(lane0), .hit_addr(hit_addr), .hit_size(hit_size), .hit_en(hit_en),
    .hit_mirr(hit_mirr), .mirr_sel(mirr_sel), .r_addr(desc_addr),
    .r_size(desc_size), .r_en(desc_enable), .mirror(mirror_in),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag8), .cpl_dwords(cpl_dwords),
    .cpl_data(cpl_data)
  );

  AST_CPL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (cpl_valid && cpl_tag == $past(req_tag) && cpl_dwords == $past(req_dwords))); // R7
  AST_NO_CPL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !cpl_valid); // R10
  AST_MIRROR_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && hit_mirr && !enable_clr) |=> ($stable(desc_addr) && $stable(desc_size) && $stable(desc_enable))); // R6
endmodule

// File: tb/regbank_completer_bench.sv
module regbank_completer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [11:0]  req_addr = '0;
  logic [2:0]   req_dwords = 3'd1;
  logic [7:0]   req_tag = '0;
  logic [127:0] req_wdata = '0;
  logic [383:0] mirror_in;
  logic         enable_clr = 1'b0;
  logic         cpl_valid;
  logic [7:0]   cpl_tag;
  logic [2:0]   cpl_dwords;
  logic [127:0] cpl_data;
  logic [127:0] desc_addr, desc_size, desc_enable;

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  logic [127:0] m_addr, m_size, m_en;

  always #2.5 clk = ~clk;

  regbank_completer u_regbank_completer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_dwords(req_dwords), .req_tag(req_tag),
    .req_wdata(req_wdata), .mirror_in(mirror_in), .enable_clr(enable_clr),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_dwords(cpl_dwords),
    .cpl_data(cpl_data), .desc_addr(desc_addr), .desc_size(desc_size),
    .desc_enable(desc_enable)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_get(input logic [11:0] a);
    int idx;
    idx = int'(a[11:4]);
    if (idx == 0) return m_addr;
    if (idx == 1) return m_size;
    if (idx == 64) return m_en;
    if (idx >= 48 && idx <= 50) return mirror_in[(idx-48)*128 +: 128];
    return '0;
  endfunction

  function automatic logic [127:0] model_write(input logic [127:0] old, input logic [11:0] a,
                                               input logic [2:0] n, input logic [127:0] d);
    logic [127:0] r;
    r = old;
    for (int k = 0; k < int'(n); k++) r[((int'(a[3:2]) + k) % 4)*32 +: 32] = d[k*32 +: 32];
    return r;
  endfunction

  function automatic logic [127:0] model_read(input logic [11:0] a, input logic [2:0] n);
    logic [127:0] src, r;
    src = model_get(a);
    r = '0;
    for (int k = 0; k < int'(n); k++) r[k*32 +: 32] = src[((int'(a[3:2]) + k) % 4)*32 +: 32];
    return r;
  endfunction

  task automatic cmp_regs(input string req);
    check(desc_addr == m_addr, req, desc_addr, m_addr);
    check(desc_size == m_size, req, desc_size, m_size);
    check(desc_enable == m_en, req, desc_enable, m_en);
  endtask

  task automatic access(input bit wr, input logic [11:0] a, input logic [2:0] n,
                        input logic [7:0] t, input logic [127:0] d, input bit clr, input string req);
    logic [127:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_dwords = n;
    req_tag = t; req_wdata = d; enable_clr = clr;
    exp = model_read(a, n);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; enable_clr = 1'b0;
    if (wr) begin
      if (a[11:4] == 8'd0) m_addr = model_write(m_addr, a, n, d);
      else if (a[11:4] == 8'd1) m_size = model_write(m_size, a, n, d);
      else if (a[11:4] == 8'd64) m_en = model_write(m_en, a, n, d);
      else if (clr) m_en[0] = 1'b0;
      if (clr && a[11:4] != 8'd0 && a[11:4] != 8'd1) begin end
      if (clr && (a[11:4] == 8'd0 || a[11:4] == 8'd1)) m_en[0] = 1'b0;
      check(cpl_valid == 1'b0, {req, " R10 no completion"}, 128'(cpl_valid), 128'd0);
      cmp_regs(req);
    end else begin
      if (clr) m_en[0] = 1'b0;
      check(cpl_valid == 1'b1, {req, " R7 valid"}, 128'(cpl_valid), 128'd1);
      check(cpl_tag == t && cpl_dwords == n, {req, " R7 tag/count"},
            {cpl_tag, 5'd0, cpl_dwords}, {t, 5'd0, n});
      check(cpl_data == exp, req, cpl_data, exp);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [11:0] a;
    logic [2:0]  n;
    bit          wr;
    void'($urandom(32'h5eed_1234));
    mirror_in = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                 $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    m_addr = '0; m_size = '0; m_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(cpl_valid == 1'b0, "R1 cpl idle", 128'(cpl_valid), 128'd0);
    cmp_regs("R1 reset registers");

    // R3 single-word lane writes
    access(1, 12'h004, 3'd1, 8'h01, 128'h1111_2222, 0, "R3 lane1 write");
    access(1, 12'h00C, 3'd1, 8'h02, 128'hAAAA_BBBB, 0, "R3 lane3 write");
    // R2 low bits ignored
    access(1, 12'h003, 3'd1, 8'h03, 128'h0000_0C0C, 0, "R2 misaligned write");
    access(0, 12'h006, 3'd1, 8'h04, '0, 0, "R2 misaligned read");
    // R5 end address at 0x8 as 64-bit, start at 0x0
    access(1, 12'h008, 3'd2, 8'h05, 128'h0000_0000_0000_0000_0000_0001_0000_87FF, 0, "R5 end address");
    access(1, 12'h000, 3'd2, 8'h06, 128'h0000_0000_0000_0000_0000_0000_0002_8000, 0, "R5 start address");
    access(1, 12'h010, 3'd4, 8'h07, 128'h4444_3333_2222_0000_0000_0000_0000_0FFF, 0, "R5 size 128-bit");
    // R4 wrap: 4 words starting at lane 2, 3 words starting at lane 3
    access(1, 12'h018, 3'd4, 8'h08, 128'hD4D4_D4D4_C3C3_C3C3_B2B2_B2B2_A1A1_A1A1, 0, "R4 wrap write");
    access(0, 12'h01C, 3'd3, 8'h09, '0, 0, "R4 wrap read");
    access(0, 12'h008, 3'd2, 8'h0A, '0, 0, "R4 64-bit read");
    // R6 mirror read and write-ignore
    access(0, 12'h300, 3'd4, 8'h0B, '0, 0, "R6 mirror0 read");
    access(1, 12'h314, 3'd2, 8'h0C, {4{32'hFFFF_FFFF}}, 0, "R6 mirror write ignored");
    access(0, 12'h310, 3'd4, 8'h0D, '0, 0, "R6 mirror1 unchanged");
    access(0, 12'h328, 3'd2, 8'h0E, '0, 0, "R6 mirror2 read");
    // R8 unmapped
    access(1, 12'h200, 3'd4, 8'h0F, {4{32'h5A5A_5A5A}}, 0, "R8 unmapped write");
    access(0, 12'h200, 3'd4, 8'h10, '0, 0, "R8 unmapped read");
    access(0, 12'h330, 3'd4, 8'h11, '0, 0, "R8 past mirror read");
    // R9 enable set, clear strobe, and write-wins
    access(1, 12'h400, 3'd1, 8'h12, 128'h1, 0, "R9 enable set");
    @(negedge clk); enable_clr = 1'b1;
    @(posedge clk); @(negedge clk); enable_clr = 1'b0; m_en[0] = 1'b0;
    cmp_regs("R9 clear strobe");
    access(1, 12'h400, 3'd1, 8'h13, 128'h1, 1, "R9 write beats clear");
    access(0, 12'h400, 3'd1, 8'h14, '0, 0, "R9 enable readback");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 6)
        0: a = 12'h000; 1: a = 12'h010; 2: a = 12'h400;
        3: a = 12'h300 + 12'(($urandom % 3) * 16);
        4: a = 12'(($urandom % 256) * 16);
        default: a = 12'h000;
      endcase
      a[3:0] = 4'($urandom);
      n = 3'(($urandom % 4) + 1);
      wr = 1'($urandom);
      access(wr, a, n, 8'($urandom),
             {$urandom, $urandom, $urandom, $urandom}, 1'(($urandom % 8) == 0),
             "R4 R7 R8 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule